// File: doc/BRIEF.md
# Converter Sample Demultiplexer with Resettable Half-Rate Clock

This block sits behind a converter core that produces one 8-bit code per input clock. It hands the codes to the downstream logic in one of two modes, chosen by a static mode input. In demultiplexed mode the codes are split into pairs and presented on two ports that change every second clock: the earlier code of each pair goes to port A and the later code goes to port B. A registered divide-by-2 clock comes out alongside the ports. In straight mode every code goes to port A at the full clock rate, and the clock output is the inverted input clock.

The block has a synchronous reset. The reset returns the divide-by-2 phase to a known state, so several instances that share a clock and a reset pair their codes identically. An output polarity input selects between plain binary codes and codes with every bit inverted. The polarity is applied to each code as it is captured. The mode input is treated as static. After any change of mode, the system must apply a reset before the outputs are used.

Top module: `adc_sample_demux`

## Requirements
- R1: While `rst` is high at a rising clock edge, both ports and the registered divide-by-2 clock go to zero after that edge. In demultiplexed mode `clk_out` therefore reads 0 during reset.
- R2: In straight mode (`dmux_mode` = 0), the code presented at edge k appears on `port_a` after edge k+1. `port_a` takes a new value at every edge.
- R3: In straight mode, `port_b` reads all zeros whatever the codes and the polarity.
- R4: In straight mode, `clk_out` is the inverse of `clk`: it is 0 while `clk` is high and 1 while `clk` is low.
- R5: In demultiplexed mode (`dmux_mode` = 1), number the codes from 0 at the first edge after reset. After edge 2k+2, `port_a` holds code 2k (even index) and `port_b` holds code 2k+1 (odd index). Both ports read 0 after edges 0 and 1.
- R6: In demultiplexed mode, the two ports change only at the same edge, and only at every second edge. After edge 2k+3 they still hold what they showed after edge 2k+2.
- R7: In demultiplexed mode, `clk_out` is a registered divide-by-2. It reads k mod 2 after edge k, so it falls at the edge where the ports update and rises one input clock later, in the middle of the port data window.
- R8: When `pol_true` = 1, the output code equals the input code. When `pol_true` = 0, every bit of the output is inverted. The polarity is sampled together with each code at its capture edge.
- R9: A reset applied in the middle of a demultiplexed stream, at either phase, restarts the pairing. The first code after the release goes to `port_a`, with the timing of R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Converter sample clock, one code per rising edge |
| rst | input | 1 | Synchronous active-high reset of the divide-by-2 phase and the output registers |
| dmux_mode | input | 1 | 1 selects demultiplexed two-port output, 0 selects straight single-port output |
| pol_true | input | 1 | 1 gives plain binary codes, 0 inverts every output bit |
| code_in | input | 8 | Code from the converter core |
| port_a | output | 8 | Even-indexed codes (demultiplexed mode) or every code (straight mode) |
| port_b | output | 8 | Odd-indexed codes (demultiplexed mode), zero in straight mode |
| clk_out | output | 1 | Divided clock in demultiplexed mode, inverted input clock in straight mode |

## Verification
An incrementing code ramp gives each code a distinct value. It shows whether a code lands on the correct port at the correct edge, and whether the pair order is swapped or shifted by one clock. An alternating 0x00/0xFF stream, a stream around mid-scale (0x7F/0x80), and a stream with the polarity changed at every code separate true inversion from stuck or partly inverted bits, and show that polarity is taken at capture rather than at output. A reset applied mid-stream after an odd number of edges, and again after an even number, shows whether the pairing phase really restarts or only happens to line up.

// File: rtl/adc_demux_pkg.sv
package adc_demux_pkg;

  localparam int CODE_W_DEF = 8;

  typedef enum logic {
    OUT_STRAIGHT = 1'b0,
    OUT_DMUX     = 1'b1
  } out_mode_e;

endpackage

// File: rtl/adc_code_capture.sv
module adc_code_capture #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         pol_true,
  input  logic [W-1:0] code_in,
  output logic [W-1:0] cap_q
);

  logic [W-1:0] lane_d;

  // one XNOR lane per bit: pol_true=1 passes, 0 inverts
  for (genvar i = 0; i < W; i++) begin : g_lane
    assign lane_d[i] = ~(code_in[i] ^ pol_true);
  end

  always_ff @(posedge clk) begin
    if (rst) cap_q <= '0;
    else     cap_q <= lane_d;
  end

endmodule

// File: rtl/adc_phase_div.sv
module adc_phase_div (
  input  logic clk,
  input  logic rst,
  output logic div_q
);

  logic phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= 1'b0;
      div_q   <= 1'b0;
    end else begin
      phase_q <= ~phase_q;
      div_q   <= phase_q;
    end
  end

endmodule

// File: rtl/adc_port_pack.sv
module adc_port_pack
  import adc_demux_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  out_mode_e    mode,
  input  logic         pair_rdy,
  input  logic [W-1:0] cap_q,
  output logic [W-1:0] port_a,
  output logic [W-1:0] port_b
);

  logic [W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      port_a <= '0;
      port_b <= '0;
    end else begin
      hold_q <= cap_q;
      if (mode == OUT_STRAIGHT) begin
        port_a <= cap_q;
        port_b <= '0;
      end else if (pair_rdy) begin
        port_a <= hold_q;
        port_b <= cap_q;
      end
    end
  end

endmodule

// File: rtl/adc_clkout_sel.sv
module adc_clkout_sel
  import adc_demux_pkg::*;
(
  input  logic      clk,
  input  out_mode_e mode,
  input  logic      div_q,
  output logic      clk_out
);

  always_comb begin
    if (mode == OUT_DMUX) clk_out = div_q;
    else                  clk_out = ~clk;
  end

endmodule

// File: rtl/adc_sample_demux.sv
module adc_sample_demux
  import adc_demux_pkg::*;
#(
  parameter int W = CODE_W_DEF
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         dmux_mode,
  input  logic         pol_true,
  input  logic [W-1:0] code_in,
  output logic [W-1:0] port_a,
  output logic [W-1:0] port_b,
  output logic         clk_out
);

  out_mode_e    mode;
  logic [W-1:0] cap_q;
  logic         div_q;

  assign mode = out_mode_e'(dmux_mode);

  adc_code_capture #(.W(W)) u_cap (
    .clk(clk), .rst(rst), .pol_true(pol_true), .code_in(code_in), .cap_q(cap_q)
  );

  adc_phase_div u_div (
    .clk(clk), .rst(rst), .div_q(div_q)
  );

  adc_port_pack #(.W(W)) u_pack (
    .clk(clk), .rst(rst), .mode(mode), .pair_rdy(div_q),
    .cap_q(cap_q), .port_a(port_a), .port_b(port_b)
  );

  adc_clkout_sel u_clk (
    .clk(clk), .mode(mode), .div_q(div_q), .clk_out(clk_out)
  );

endmodule

// File: rtl/adc_sample_demux_chk.sv
module adc_sample_demux_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         dmux_mode,
  input logic         pol_true,
  input logic [W-1:0] code_in,
  input logic [W-1:0] port_a,
  input logic [W-1:0] port_b,
  input logic         clk_out
);

  p_reset_clears_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (port_a == '0 && port_b == '0));

  p_straight_latency_r2: assert property (@(posedge clk) disable iff (rst)
    (!dmux_mode && $past(!dmux_mode) && !$past(rst) && !$past(rst, 2)) |->
      port_a == ($past(pol_true, 2) ? $past(code_in, 2) : ~$past(code_in, 2)));

  p_straight_b_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (!dmux_mode && $past(!dmux_mode) && !$past(rst)) |-> port_b == '0);

  // R6: ports move together, only at the divided-clock falling edge
  p_pair_stable_r6: assert property (@(posedge clk) disable iff (rst)
    (dmux_mode && $past(dmux_mode) && !($past(clk_out) && !clk_out)) |->
      ($stable(port_a) && $stable(port_b)));

  p_div_toggle_r7: assert property (@(posedge clk) disable iff (rst)
    (dmux_mode && $past(dmux_mode) && !$past(rst) && !$past(rst, 2)) |->
      clk_out != $past(clk_out));

endmodule

bind adc_sample_demux adc_sample_demux_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .dmux_mode(dmux_mode), .pol_true(pol_true),
  .code_in(code_in), .port_a(port_a), .port_b(port_b), .clk_out(clk_out)
);

// File: tb/tb_adc_sample_demux.sv
module tb_adc_sample_demux;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         dmux_mode = 1'b1;
  logic         pol_true = 1'b1;
  logic [W-1:0] code_in = '0;
  logic [W-1:0] port_a, port_b;
  logic         clk_out;

  int checks = 0;
  int failures = 0;
  logic [W-1:0] exp_q [0:63];

  always #10 clk = ~clk;

  adc_sample_demux #(.W(W)) dut (
    .clk(clk), .rst(rst), .dmux_mode(dmux_mode), .pol_true(pol_true),
    .code_in(code_in), .port_a(port_a), .port_b(port_b), .clk_out(clk_out)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] apply_pol(input logic [W-1:0] v, input logic p);
    return p ? v : ~v;
  endfunction

  // reset held across two edges, released at a falling edge
  task automatic do_reset(input logic mode);
    @(negedge clk);
    rst = 1'b1;
    dmux_mode = mode;
    @(posedge clk);
    @(posedge clk);
    #2;
    chk("R1 port_a in reset", port_a, '0);
    chk("R1 port_b in reset", port_b, '0);
    if (mode) chk("R1 clk_out in reset", {7'b0, clk_out}, 8'h00);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // drive code for edge k (already past the falling edge at entry)
  task automatic drive(input int k, input logic [W-1:0] v, input logic p);
    code_in  = v;
    pol_true = p;
    exp_q[k] = apply_pol(v, p);
    @(posedge clk);
    #2;
  endtask

  task automatic t_straight(input int pat, input int n);
    do_reset(1'b0);
    for (int k = 0; k < n; k++) begin
      logic [W-1:0] v;
      logic p;
      case (pat)
        0: begin v = W'(k * 7 + 3); p = 1'b1; end
        1: begin v = (k % 2) ? 8'hFF : 8'h00; p = 1'b0; end
        default: begin v = (k % 2) ? 8'h80 : 8'h7F; p = k[1]; end
      endcase
      if (k < 3) chk("R4 clk_out while clk low", {7'b0, clk_out}, 8'h01);
      drive(k, v, p);
      if (k < 3) begin
        #3;
        chk("R4 clk_out while clk high", {7'b0, clk_out}, 8'h00);
      end
      chk("R2 R8 straight port_a", port_a, (k >= 1) ? exp_q[k-1] : 8'h00);
      chk("R3 straight port_b zero", port_b, 8'h00);
      @(negedge clk);
    end
  endtask

  task automatic check_dmux_edge(input int k);
    logic [W-1:0] ea, eb;
    int j;
    chk("R7 divided clk_out", {7'b0, clk_out}, 8'(k % 2));
    if (k < 2) begin
      ea = '0; eb = '0;
    end else begin
      j = ((k - 2) / 2) * 2;
      ea = exp_q[j];
      eb = exp_q[j+1];
    end
    if (k % 2 == 1) begin
      chk("R6 port_a held", port_a, ea);
      chk("R6 port_b held", port_b, eb);
    end else begin
      chk("R5 R8 port_a even code", port_a, ea);
      chk("R5 R8 port_b odd code", port_b, eb);
    end
  endtask

  task automatic t_dmux(input int pat, input int n);
    do_reset(1'b1);
    for (int k = 0; k < n; k++) begin
      logic [W-1:0] v;
      logic p;
      case (pat)
        0: begin v = W'(16 + k); p = 1'b1; end
        1: begin v = (k % 2) ? 8'hFF : 8'h00; p = 1'b1; end
        default: begin v = W'(8'h7E + k); p = ~k[0]; end
      endcase
      drive(k, v, p);
      check_dmux_edge(k);
      @(negedge clk);
    end
  endtask

  // R9: run a stream, cut it with reset after `cut` edges, restart
  task automatic t_realign(input int cut);
    do_reset(1'b1);
    for (int k = 0; k < cut; k++) begin
      drive(k, W'(8'hA0 + k), 1'b1);
      @(negedge clk);
    end
    do_reset(1'b1);
    for (int k = 0; k < 8; k++) begin
      drive(k, W'(8'h40 + 3 * k), 1'b1);
      if (k >= 2 && k % 2 == 0) begin
        chk("R9 realigned port_a", port_a, exp_q[k-2]);
        chk("R9 realigned port_b", port_b, exp_q[k-1]);
      end
      chk("R9 realigned clk_out", {7'b0, clk_out}, 8'(k % 2));
      @(negedge clk);
    end
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_straight(0, 10);
    t_straight(1, 8);
    t_straight(2, 8);
    t_dmux(0, 12);
    t_dmux(1, 10);
    t_dmux(2, 10);
    t_realign(5);
    t_realign(6);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule